// File: doc/BRIEF.md
# Routed Interrupt Aggregator

This block collects thirty-two level-sensitive interrupt sources and presents them on eight upstream CPU interrupt lines. Software enables sources through a mask register. Each source has a four-bit route field that names the upstream line it drives. An upstream line stays high while at least one source routed to it is both active and enabled.

The raw source levels are captured once per clock into a status register that software can read. The enabled and active sources together form the pending set. The block also reports the index of the lowest pending source, so a dispatcher can find it without scanning bits.

Access uses a plain strobe interface. It has a write enable, a read enable, a five-bit byte address and 32-bit data. Read data is combinational from the address. Only the upper three address bits select a register.

Top module: `irq_route_agg`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the mask, status and all route registers read zero. In that first cycle all upstream lines are low and `low_vld_o` is low.
- R2: Offset 0x00 is the mask register and can be read and written. Bit n set enables source n; bit n clear disables it.
- R3: Offset 0x04 reads the source inputs as they were sampled at the previous clock edge. A write to 0x04 changes nothing.
- R4: Offsets 0x08, 0x0C, 0x10 and 0x14 are route registers, each read/write across all 32 bits. The field of source n is bits [(n*4)%32 +: 4] of packed word (n*4)/32. Packed word 0 lives at 0x14, word 1 at 0x10, word 2 at 0x0C and word 3 at 0x08.
- R5: Upstream line k (bit k of `cpu_irq_o`) is high exactly when some source n has route field k, its mask bit set and its status bit set. The line follows a register write or a status change from the edge that captures it.
- R6: A route field value of 8 to 15 drives no upstream line, but that source still counts as pending for `low_vld_o` and `low_idx_o`.
- R7: `low_vld_o` is high exactly when (mask AND status) is nonzero. In that case `low_idx_o` is the index of its lowest set bit; otherwise `low_idx_o` is 0.
- R8: Reads of offsets 0x18 and 0x1C return zero, and writes there change no register.
- R9: `rdata_o` is zero whenever `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Raw level of each interrupt source |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 5 | Byte offset; bits [4:2] select a register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| cpu_irq_o | output | 8 | Upstream CPU interrupt lines |
| low_idx_o | output | 5 | Index of the lowest pending source |
| low_vld_o | output | 1 | Some source is pending |

## Verification
The reversed packing is tested at both ends. Source 0 goes through bits [3:0] at 0x14, and source 31 goes through bits [31:28] at 0x08. A design that stores words in address order would raise the wrong line for both. A source parked on route value 9 must raise no line but must still be reported as the lowest pending source. A design that truncates the field to three bits would raise line 1 instead.

Writes aimed at the status register and at the two unused offsets are followed by reads. A design that decodes those writes would corrupt the status or the mask. Random source, mask and route traffic then checks the OR reduction and the lowest-index priority against a bench model.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int NUM_SRC  = 32;
    localparam int NUM_LINE = 8;
    localparam int FLD_W    = 4;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int SRC_PER_WORD = DATA_W / FLD_W;
    localparam int NUM_RWORD    = NUM_SRC / SRC_PER_WORD;
    localparam int IDX_W        = $clog2(NUM_SRC);
    localparam int SLOT_W       = ADDR_W - 2;
    localparam int RT_BASE_SLOT = 2;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_MASK = 3'd0,
        SLOT_STAT = 3'd1,
        SLOT_PW3  = 3'd2,
        SLOT_PW2  = 3'd3,
        SLOT_PW1  = 3'd4,
        SLOT_PW0  = 3'd5,
        SLOT_GAP0 = 3'd6,
        SLOT_GAP1 = 3'd7
    } slot_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        slot_e             slot;
        logic [DATA_W-1:0] data;
    } reg_req_t;

    // Register slot that holds packed route word w (stored in reverse order)
    function automatic slot_e pw_slot(input int w);
        return slot_e'(RT_BASE_SLOT + NUM_RWORD - 1 - w);
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  reg_req_t                          req,
    input  logic [NUM_SRC-1:0]                src_i,
    output logic [NUM_SRC-1:0]                mask_q,
    output logic [NUM_SRC-1:0]                stat_q,
    output logic [NUM_RWORD-1:0][DATA_W-1:0]  route_q,
    output logic [DATA_W-1:0]                 rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            stat_q  <= '0;
            route_q <= '0;
        end else begin
            stat_q <= src_i;
            if (req.wr && req.slot == SLOT_MASK) begin
                mask_q <= req.data;
            end
            for (int w = 0; w < NUM_RWORD; w++) begin
                if (req.wr && req.slot == pw_slot(w)) begin
                    route_q[w] <= req.data;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (req.rd) begin
            if (req.slot == SLOT_MASK) rdata = mask_q;
            if (req.slot == SLOT_STAT) rdata = stat_q;
            for (int w = 0; w < NUM_RWORD; w++) begin
                if (req.slot == pw_slot(w)) rdata = route_q[w];
            end
        end
    end

endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
    import irq_route_pkg::*;
(
    input  logic [NUM_RWORD-1:0][DATA_W-1:0] route_q,
    input  logic [NUM_SRC-1:0]               act,
    output logic [NUM_LINE-1:0]              lines
);

    logic [NUM_SRC-1:0][FLD_W-1:0] fld;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_fld
        assign fld[n] = route_q[(n * FLD_W) / DATA_W][(n * FLD_W) % DATA_W +: FLD_W];
    end

    for (genvar k = 0; k < NUM_LINE; k++) begin : g_line
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int n = 0; n < NUM_SRC; n++) begin
                if (act[n] && fld[n] == FLD_W'(k)) hit = 1'b1;
            end
        end
        assign lines[k] = hit;
    end

endmodule

// File: rtl/irq_route_prio.sv
module irq_route_prio
    import irq_route_pkg::*;
(
    input  logic [NUM_SRC-1:0] act,
    output logic [IDX_W-1:0]   idx,
    output logic               vld
);

    always_comb begin
        idx = '0;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (act[n]) idx = IDX_W'(n);
        end
        vld = |act;
    end

endmodule

// File: rtl/irq_route_agg.sv
module irq_route_agg
    import irq_route_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [NUM_LINE-1:0] cpu_irq_o,
    output logic [IDX_W-1:0]    low_idx_o,
    output logic                low_vld_o
);

    reg_req_t                         req;
    logic [NUM_SRC-1:0]               mask_q;
    logic [NUM_SRC-1:0]               stat_q;
    logic [NUM_RWORD-1:0][DATA_W-1:0] route_q;
    logic [NUM_SRC-1:0]               pend;

    assign req.wr   = wr_en_i;
    assign req.rd   = rd_en_i;
    assign req.slot = slot_e'(addr_i[ADDR_W-1:2]);
    assign req.data = wdata_i;

    irq_route_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .src_i   (src_i),
        .mask_q  (mask_q),
        .stat_q  (stat_q),
        .route_q (route_q),
        .rdata   (rdata_o)
    );

    assign pend = mask_q & stat_q;

    irq_route_matrix u_matrix (
        .route_q (route_q),
        .act     (pend),
        .lines   (cpu_irq_o)
    );

    irq_route_prio u_prio (
        .act (pend),
        .idx (low_idx_o),
        .vld (low_vld_o)
    );

endmodule

// File: rtl/irq_route_agg_chk.sv
module irq_route_agg_chk
    import irq_route_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [NUM_SRC-1:0]  src_i,
    input logic                rd_en_i,
    input logic [ADDR_W-1:0]   addr_i,
    input logic [DATA_W-1:0]   rdata_o,
    input logic [NUM_SRC-1:0]  mask_q,
    input logic [NUM_SRC-1:0]  stat_q,
    input logic [NUM_LINE-1:0] cpu_irq_o,
    input logic [IDX_W-1:0]    low_idx_o,
    input logic                low_vld_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cpu_irq_o == '0 && !low_vld_o));

    // R5
    no_pend_no_line_chk: assert property (@(posedge clk) disable iff (rst)
        !low_vld_o |-> cpu_irq_o == '0);

    // R7
    low_idx_pending_chk: assert property (@(posedge clk) disable iff (rst)
        low_vld_o |-> (mask_q[low_idx_o] && stat_q[low_idx_o]));

    // R7
    low_idx_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        low_vld_o |-> ((mask_q & stat_q) & ((32'd1 << low_idx_o) - 32'd1)) == '0);

    // R3
    stat_sample_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rd_en_i && addr_i[ADDR_W-1:2] == 3'd1) |-> rdata_o == $past(src_i));

    // R8
    gap_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_i[ADDR_W-1:2] >= 3'd6) |-> rdata_o == '0);

    // R9
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |-> rdata_o == '0);

endmodule

bind irq_route_agg irq_route_agg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .rdata_o   (rdata_o),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .cpu_irq_o (cpu_irq_o),
    .low_idx_o (low_idx_o),
    .low_vld_o (low_vld_o)
);

// File: tb/irq_route_agg_tb.sv
`timescale 1ns/1ps
module irq_route_agg_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [4:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [7:0]  cpu_irq_o;
    logic [4:0]  low_idx_o;
    logic        low_vld_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [31:0] m_mask = '0;
    logic [31:0] m_stat = '0;
    logic [31:0] m_rw [4];

    always #2.5 clk = ~clk;

    irq_route_agg u_dut (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .cpu_irq_o (cpu_irq_o),
        .low_idx_o (low_idx_o),
        .low_vld_o (low_vld_o)
    );

    function automatic logic [3:0] exp_field(input int n);
        logic [31:0] w;
        w = m_rw[n / 8];
        return w[(n % 8) * 4 +: 4];
    endfunction

    function automatic logic [7:0] exp_lines();
        logic [7:0] r;
        logic [3:0] f;
        r = '0;
        for (int n = 0; n < 32; n++) begin
            f = exp_field(n);
            if (m_mask[n] && m_stat[n] && f < 4'd8) r[f[2:0]] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [5:0] exp_low();
        logic [31:0] p;
        p = m_mask & m_stat;
        for (int n = 0; n < 32; n++) begin
            if (p[n]) return {1'b1, 5'(n)};
        end
        return 6'd0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a[4:2])
            3'd0: return m_mask;
            3'd1: return m_stat;
            3'd2: return m_rw[3];
            3'd3: return m_rw[2];
            3'd4: return m_rw[1];
            3'd5: return m_rw[0];
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs();
        logic [5:0] lo;
        lo = exp_low();
        check("R5 lines", {24'd0, cpu_irq_o}, {24'd0, exp_lines()});
        check("R7 valid", {31'd0, low_vld_o}, {31'd0, lo[5]});
        check("R7 index", {27'd0, low_idx_o}, {27'd0, lo[4:0]});
        check("R9 idle read", rdata_o, 32'd0);
    endtask

    task automatic cyc(input logic [31:0] s, input logic wr, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        src_i = s; wr_en_i = wr; addr_i = a; wdata_i = d; rd_en_i = 1'b0;
        @(posedge clk);
        if (wr) begin
            case (a[4:2])
                3'd0: m_mask = d;
                3'd2: m_rw[3] = d;
                3'd3: m_rw[2] = d;
                3'd4: m_rw[1] = d;
                3'd5: m_rw[0] = d;
                default: ;
            endcase
        end
        m_stat = s;
        #1;
        check_outs();
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] a);
        @(negedge clk);
        wr_en_i = 1'b0; rd_en_i = 1'b1; addr_i = a;
        #1;
        check(req, rdata_o, exp_read(a));
        rd_en_i = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int w = 0; w < 4; w++) m_rw[w] = '0;
        src_i = 32'hffff_ffff;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state while reset high
        check("R1 lines in reset", {24'd0, cpu_irq_o}, 32'd0);
        rd_en_i = 1'b1; addr_i = 5'h00; #0.5;
        check("R1 mask in reset", rdata_o, 32'd0);
        addr_i = 5'h04; #0.5;
        check("R1 status in reset", rdata_o, 32'd0);
        rd_en_i = 1'b0;
        @(negedge clk);
        src_i = 32'd0;
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1 lines after reset", {24'd0, cpu_irq_o}, 32'd0);
        check("R1 valid after reset", {31'd0, low_vld_o}, 32'd0);
        for (int a = 0; a < 8; a++) rd("R1 readback", 5'(a * 4));

        // R4: reverse packing, both ends
        cyc(32'd0, 1'b1, 5'h14, 32'h0000_0003);
        cyc(32'd0, 1'b1, 5'h08, 32'h6000_0000);
        // R2: enabling sources
        cyc(32'd0, 1'b1, 5'h00, 32'h8000_0001);
        rd("R2 mask readback", 5'h00);
        rd("R4 route 0x14", 5'h14);
        rd("R4 route 0x08", 5'h08);
        cyc(32'h8000_0000, 1'b0, 5'h00, 32'd0);
        check("R4 src31 to line6", {24'd0, cpu_irq_o}, 32'h40);
        check("R7 idx 31", {27'd0, low_idx_o}, 32'd31);
        cyc(32'h8000_0001, 1'b0, 5'h00, 32'd0);
        check("R4 src0 to line3", {24'd0, cpu_irq_o}, 32'h48);
        check("R7 idx 0", {27'd0, low_idx_o}, 32'd0);
        // R2: disabling source 31
        cyc(32'h8000_0001, 1'b1, 5'h00, 32'h0000_0001);
        check("R2 masked src31", {24'd0, cpu_irq_o}, 32'h08);

        // R6: route value 9 drives no line but stays pending
        cyc(32'h0000_1000, 1'b1, 5'h10, 32'h0009_0000);
        cyc(32'h0000_1000, 1'b1, 5'h00, 32'h0000_1000);
        check("R6 no line", {24'd0, cpu_irq_o}, 32'd0);
        check("R6 still pending", {26'd0, low_vld_o, low_idx_o}, {26'd0, 1'b1, 5'd12});

        // R3: status ignores writes
        cyc(32'h1234_5678, 1'b1, 5'h04, 32'hffff_ffff);
        rd("R3 status after write", 5'h04);
        check("R3 status value", exp_read(5'h04), 32'h1234_5678);

        // R8: gap offsets
        cyc(32'h1234_5678, 1'b1, 5'h18, 32'hffff_ffff);
        cyc(32'h1234_5678, 1'b1, 5'h1c, 32'hffff_ffff);
        rd("R8 gap 0x18", 5'h18);
        rd("R8 gap 0x1c", 5'h1c);
        for (int a = 0; a < 6; a++) rd("R8 no side effect", 5'(a * 4));

        // Random traffic for R2 R4 R5 R7
        for (int i = 0; i < 600; i++) begin
            logic [31:0] s;
            logic [31:0] d;
            logic        w;
            logic [4:0]  a;
            s = $urandom() & $urandom();
            w = ($urandom_range(0, 3) == 0);
            a = 5'($urandom_range(0, 7) * 4);
            d = $urandom();
            if (a[4:2] >= 3'd2 && a[4:2] <= 3'd5 && $urandom_range(0, 1) == 1)
                d = d & 32'h7777_7777;
            cyc(s, w, a, d);
            if (i % 25 == 0) begin
                for (int r = 0; r < 8; r++) rd("R4 random readback", 5'(r * 4));
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule